// File: doc/BRIEF.md
# Transmit Queue Control Register Bank

This block holds the software-visible control state for four transmit queues. Each queue owns two 32-bit registers: a control word and a head write-back address word. Both are reached through a simple single-cycle register bus. The per-queue register windows repeat at a fixed address stride, so software reaches queue `q` by adding `q` times the stride to a common base. The bank drives the transmit engine directly with the following per-queue signals:

- enable, arbitration priority and a descriptor-flush pulse;
- a queue-initialise pulse;
- the head write-back enable and the descriptor write-back enable;
- the DWORD-aligned write-back address.

Turning a queue off is a handshake with the datapath, not an immediate action. When software clears the enable bit of a busy queue, the bank records a pending disable and keeps the queue enabled. The queue drops only when its idle input is seen. A global transmit-enable input masks every queue's enable, both on the outputs and on reads. When head write-back is selected for a queue, that queue's descriptor write-back output is forced off.

Top module: `txq_ctl_bank`

## Requirements
- R1: Queue `q` (0..3) has its control word at byte address 0x3828 + 0x100*q and its write-back word at 0x3838 + 0x100*q. A read with `rd_en` high presents data on `rdata` after the next clock edge and holds it for one cycle. `rdata` is 0 in any cycle not following a read. Reads of any other address return 0, and writes to any other address change nothing.
- R2: After reset, the control word of queue 0 reads 0x1 and that of queues 1..3 reads 0x0. Every write-back word reads 0. `q_enable` is 4'b0001 and every pulse and pending flag is 0.
- R3: A control write with bit 0 = 1 while `tx_global_en` is high raises that queue's `q_init` for exactly the one cycle after the write edge. No other queue's `q_init` rises.
- R4: A control write with bit 0 = 0 to an enabled queue whose `q_idle` is high clears the enable at that edge. If `q_idle` is low, the enable stays 1, reads back 1, and `q_disable_pending` is set. Both clear at the first edge where `q_idle` is high.
- R5: While `tx_global_en` is low, `q_enable` is 0 and control-word bit 0 reads 0 for every queue, and no `q_init` is issued. A stored enable reappears when `tx_global_en` returns high.
- R6: Control bit 1 written as 1 raises `q_flush` for exactly the one cycle after the write edge. Bit 1 reads back 0 once that cycle has passed.
- R7: Control bit 2 is stored and drives `q_prio`, where 0 means low priority and 1 means high priority.
- R8: Control bit 3 is the descriptor write-back enable and write-back word bit 0 is the head write-back enable. `q_desc_wb_en` equals bit 3 AND NOT head enable, and `q_head_wb_en` follows write-back bit 0.
- R9: Write-back word bits 31:2 hold the address and bit 1 is reserved. A read returns the written value with bit 1 forced to 0. The `q_wb_addr` slice for queue `q` (bits 32q+31:32q) carries bits 31:2 with bits 1:0 equal to 0.
- R10: Control-word bits 31:4 ignore writes and read 0.
- R11: A control write with bit 0 = 1 to a queue with a pending disable cancels the pending disable. This holds even in the edge where `q_idle` rises. The enable stays 1 and `q_init` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_global_en | input | 1 | Global transmit enable; masks all queue enables |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, one cycle after `rd_en` |
| q_idle | input | 4 | Per-queue datapath idle indication |
| q_enable | output | 4 | Per-queue effective enable |
| q_prio | output | 4 | Per-queue arbitration priority |
| q_flush | output | 4 | Per-queue descriptor write-back flush pulse |
| q_init | output | 4 | Per-queue initialise pulse |
| q_head_wb_en | output | 4 | Per-queue head write-back enable |
| q_desc_wb_en | output | 4 | Per-queue descriptor write-back enable after override |
| q_wb_addr | output | 128 | Per-queue write-back address, 32 bits per queue |
| q_disable_pending | output | 4 | Per-queue disable waiting for idle |

## Verification
Two functions can act on the same enable register in the same edge: a software control write, and the idle-driven completion of a pending disable. The bench provokes this by first holding `q_idle` low to create a pending disable. It then drives, in one cycle, `q_idle` high together with a control write. With enable bit 1 the write must win: the queue stays enabled, the pending flag clears and `q_init` pulses. With enable bit 0 the queue must drop at that edge. Both outcomes are judged on `q_enable`, `q_disable_pending`, `q_init` and a readback of the control word.

// File: rtl/txq_ctl_pkg.sv
// Package: shared field positions, per-queue state type and word packing
// helpers for the transmit queue control bank.
// Assumes 32-bit register words.
package txq_ctl_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ADDR_LSB = 2;

    // Control word field positions
    localparam int unsigned CTL_EN_BIT    = 0;
    localparam int unsigned CTL_FLUSH_BIT = 1;
    localparam int unsigned CTL_PRIO_BIT  = 2;
    localparam int unsigned CTL_DWB_BIT   = 3;

    // Write-back word field positions
    localparam int unsigned WBL_HEN_BIT = 0;

    typedef struct packed {
        logic                       en;
        logic                       pend;
        logic                       flush;
        logic                       prio;
        logic                       dwb;
        logic                       hwb;
        logic [WORD_W-ADDR_LSB-1:0] wb_addr;
    } txq_state_t;

    // Builds the control word seen on a read; enable is masked by the global enable.
    function automatic logic [WORD_W-1:0] pack_ctl(input txq_state_t s, input logic gen);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[CTL_EN_BIT]    = s.en & gen;
        w[CTL_FLUSH_BIT] = s.flush;
        w[CTL_PRIO_BIT]  = s.prio;
        w[CTL_DWB_BIT]   = s.dwb;
        return w;
    endfunction

    // Builds the write-back word seen on a read; bit 1 is reserved and reads 0.
    function automatic logic [WORD_W-1:0] pack_wbl(input txq_state_t s);
        logic [WORD_W-1:0] w;
        w                = {s.wb_addr, {ADDR_LSB{1'b0}}};
        w[WBL_HEN_BIT]   = s.hwb;
        return w;
    endfunction

endpackage

// File: rtl/txq_addr_decode.sv
// Module: txq_addr_decode
// Turns a byte address into one-hot hit vectors for each queue's control and
// write-back words. Queue windows repeat at Q_STRIDE from BANK_BASE.
// Assumes the offsets are distinct and fit within one stride.
module txq_addr_decode #(
    parameter int          NQ        = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BANK_BASE = 32'h3800,
    parameter int unsigned Q_STRIDE  = 32'h100,
    parameter int unsigned CTL_OFS   = 32'h28,
    parameter int unsigned WBL_OFS   = 32'h38
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NQ-1:0]     ctl_hit,
    output logic [NQ-1:0]     wbl_hit
);

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_q
            localparam int unsigned Q_BASE = BANK_BASE + Q_STRIDE * q;
            localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(Q_BASE + CTL_OFS);
            localparam logic [ADDR_W-1:0] WBL_A = ADDR_W'(Q_BASE + WBL_OFS);

            // Address compare for this queue's two words.
            assign ctl_hit[q] = (addr == CTL_A);
            assign wbl_hit[q] = (addr == WBL_A);
        end
    endgenerate

endmodule

// File: rtl/txq_queue_regs.sv
// Module: txq_queue_regs
// State of one transmit queue. Applies the reset default for enable and
// self-clears the flush trigger. Defers a disable until the datapath reports
// idle, and registers the init and flush pulses.
// Assumes ctl_we and wbl_we are single-cycle strobes already gated by decode.
module txq_queue_regs
    import txq_ctl_pkg::*;
#(
    parameter logic EN_DEFAULT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen,
    input  logic              idle,
    input  logic              ctl_we,
    input  logic              wbl_we,
    input  logic [WORD_W-1:0] wdata,
    output txq_state_t        st,
    output logic              init_pulse
);

    txq_state_t st_q;
    logic       init_q;

    logic wr_en_bit;
    logic wr_dis_req;

    // Decode the enable intent of a control write.
    always_comb begin
        wr_en_bit  = ctl_we & wdata[CTL_EN_BIT];
        wr_dis_req = ctl_we & ~wdata[CTL_EN_BIT] & st_q.en;
    end

    // Enable, pending-disable handshake and initialise pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= EN_DEFAULT;
            st_q.pend <= 1'b0;
            init_q    <= 1'b0;
        end else begin
            init_q <= wr_en_bit & gen;
            if (wr_en_bit) begin
                st_q.en   <= 1'b1;
                st_q.pend <= 1'b0;
            end else if (wr_dis_req) begin
                st_q.en   <= ~idle;
                st_q.pend <= ~idle;
            end else if (st_q.pend && idle) begin
                st_q.en   <= 1'b0;
                st_q.pend <= 1'b0;
            end
        end
    end

    // Flush trigger: set by a write of 1, cleared by hardware next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flush <= 1'b0;
        end else begin
            st_q.flush <= ctl_we & wdata[CTL_FLUSH_BIT];
        end
    end

    // Priority and descriptor write-back enable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prio <= 1'b0;
            st_q.dwb  <= 1'b0;
        end else if (ctl_we) begin
            st_q.prio <= wdata[CTL_PRIO_BIT];
            st_q.dwb  <= wdata[CTL_DWB_BIT];
        end
    end

    // Head write-back enable and DWORD-aligned address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hwb     <= 1'b0;
            st_q.wb_addr <= '0;
        end else if (wbl_we) begin
            st_q.hwb     <= wdata[WBL_HEN_BIT];
            st_q.wb_addr <= wdata[WORD_W-1:ADDR_LSB];
        end
    end

    assign st         = st_q;
    assign init_pulse = init_q;

endmodule

// File: rtl/txq_rdata_mux.sv
// Module: txq_rdata_mux
// Selects the addressed register word and registers it for a one-cycle read
// latency. Returns 0 for undecoded addresses and for cycles without a read.
// Assumes at most one hit bit is set at a time.
module txq_rdata_mux
    import txq_ctl_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  gen,
    input  logic [NQ-1:0]         ctl_hit,
    input  logic [NQ-1:0]         wbl_hit,
    input  txq_state_t [NQ-1:0]   st,
    output logic [WORD_W-1:0]     rdata
);

    logic [WORD_W-1:0] sel;

    // OR-reduce the words of all hitting registers.
    always_comb begin
        sel = '0;
        for (int q = 0; q < NQ; q++) begin
            if (ctl_hit[q]) sel = sel | pack_ctl(st[q], gen);
            if (wbl_hit[q]) sel = sel | pack_wbl(st[q]);
        end
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_en ? sel : '0;
        end
    end

endmodule

// File: rtl/txq_ctl_bank.sv
// Module: txq_ctl_bank
// Register bank for NQ transmit queues. Decodes a single-cycle register bus,
// keeps per-queue control and write-back state, and drives per-queue control
// outputs to the transmit engine.
// Assumes tx_global_en and q_idle are synchronous to clk.
module txq_ctl_bank
    import txq_ctl_pkg::*;
#(
    parameter int          NQ        = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BANK_BASE = 32'h3800,
    parameter int unsigned Q_STRIDE  = 32'h100,
    parameter int unsigned CTL_OFS   = 32'h28,
    parameter int unsigned WBL_OFS   = 32'h38,
    parameter logic [NQ-1:0] EN_RESET = NQ'(1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_global_en,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NQ-1:0]        q_idle,
    output logic [NQ-1:0]        q_enable,
    output logic [NQ-1:0]        q_prio,
    output logic [NQ-1:0]        q_flush,
    output logic [NQ-1:0]        q_init,
    output logic [NQ-1:0]        q_head_wb_en,
    output logic [NQ-1:0]        q_desc_wb_en,
    output logic [NQ*32-1:0]     q_wb_addr,
    output logic [NQ-1:0]        q_disable_pending
);

    logic [NQ-1:0]       ctl_hit;
    logic [NQ-1:0]       wbl_hit;
    txq_state_t [NQ-1:0] st;

    txq_addr_decode #(
        .NQ        (NQ),
        .ADDR_W    (ADDR_W),
        .BANK_BASE (BANK_BASE),
        .Q_STRIDE  (Q_STRIDE),
        .CTL_OFS   (CTL_OFS),
        .WBL_OFS   (WBL_OFS)
    ) u_dec (
        .addr    (addr),
        .ctl_hit (ctl_hit),
        .wbl_hit (wbl_hit)
    );

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_queue
            txq_queue_regs #(
                .EN_DEFAULT (EN_RESET[q])
            ) u_regs (
                .clk        (clk),
                .rst_n      (rst_n),
                .gen        (tx_global_en),
                .idle       (q_idle[q]),
                .ctl_we     (wr_en & ctl_hit[q]),
                .wbl_we     (wr_en & wbl_hit[q]),
                .wdata      (wdata),
                .st         (st[q]),
                .init_pulse (q_init[q])
            );

            // Per-queue outputs toward the transmit engine.
            assign q_enable[q]          = st[q].en & tx_global_en;
            assign q_prio[q]            = st[q].prio;
            assign q_flush[q]           = st[q].flush;
            assign q_head_wb_en[q]      = st[q].hwb;
            assign q_desc_wb_en[q]      = st[q].dwb & ~st[q].hwb;
            assign q_wb_addr[q*32 +: 32] = {st[q].wb_addr, {ADDR_LSB{1'b0}}};
            assign q_disable_pending[q] = st[q].pend;
        end
    endgenerate

    txq_rdata_mux #(
        .NQ (NQ)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .gen     (tx_global_en),
        .ctl_hit (ctl_hit),
        .wbl_hit (wbl_hit),
        .st      (st),
        .rdata   (rdata)
    );

endmodule

// File: rtl/txq_ctl_bank_chk.sv
// Module: txq_ctl_bank_chk
// Temporal checks on the ports of txq_ctl_bank, attached by bind.
// Assumes the bus never issues a write in two consecutive cycles to one
// queue without the wr_en history showing it.
module txq_ctl_bank_chk #(
    parameter int NQ = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_global_en,
    input logic          wr_en,
    input logic          rd_en,
    input logic [31:0]   rdata,
    input logic [NQ-1:0] q_idle,
    input logic [NQ-1:0] q_enable,
    input logic [NQ-1:0] q_flush,
    input logic [NQ-1:0] q_init,
    input logic [NQ-1:0] q_head_wb_en,
    input logic [NQ-1:0] q_desc_wb_en,
    input logic [NQ-1:0] q_disable_pending
);

    assert_rdata_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == 32'h0));

    assert_no_init_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_global_en) |-> (q_init == '0));

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_chk
            assert_init_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
                q_init[i] |=> (!q_init[i] || $past(wr_en)));

            assert_flush_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
                q_flush[i] |=> (!q_flush[i] || $past(wr_en)));

            assert_drop_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(q_enable[i]) && tx_global_en && $past(tx_global_en)) |-> $past(q_idle[i]));

            assert_pending_keeps_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (q_disable_pending[i] && tx_global_en) |-> q_enable[i]);

            assert_head_overrides_R8: assert property (@(posedge clk) disable iff (!rst_n)
                q_head_wb_en[i] |-> !q_desc_wb_en[i]);
        end
    endgenerate

endmodule

bind txq_ctl_bank txq_ctl_bank_chk #(.NQ(NQ)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .tx_global_en      (tx_global_en),
    .wr_en             (wr_en),
    .rd_en             (rd_en),
    .rdata             (rdata),
    .q_idle            (q_idle),
    .q_enable          (q_enable),
    .q_flush           (q_flush),
    .q_init            (q_init),
    .q_head_wb_en      (q_head_wb_en),
    .q_desc_wb_en      (q_desc_wb_en),
    .q_disable_pending (q_disable_pending)
);

// File: tb/txq_ctl_bank_test.sv
// Bench for txq_ctl_bank: sweeps every queue through all control-bit
// patterns and several write-back words, then exercises the disable handshake,
// its same-cycle collision with a write, and the global mask.
module txq_ctl_bank_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_global_en = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [15:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [3:0]   q_idle = 4'hF;
    logic [3:0]   q_enable, q_prio, q_flush, q_init;
    logic [3:0]   q_head_wb_en, q_desc_wb_en, q_disable_pending;
    logic [127:0] q_wb_addr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] dwb_m = '0;

    always #2 clk = ~clk;

    txq_ctl_bank uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .tx_global_en      (tx_global_en),
        .wr_en             (wr_en),
        .rd_en             (rd_en),
        .addr              (addr),
        .wdata             (wdata),
        .rdata             (rdata),
        .q_idle            (q_idle),
        .q_enable          (q_enable),
        .q_prio            (q_prio),
        .q_flush           (q_flush),
        .q_init            (q_init),
        .q_head_wb_en      (q_head_wb_en),
        .q_desc_wb_en      (q_desc_wb_en),
        .q_wb_addr         (q_wb_addr),
        .q_disable_pending (q_disable_pending)
    );

    function automatic logic [15:0] ctl_a(input int q);
        return 16'(32'h3828 + 32'h100 * q);
    endfunction

    function automatic logic [15:0] wbl_a(input int q);
        return 16'(32'h3838 + 32'h100 * q);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset defaults
        check("R2 enable", 32'(q_enable), 32'h1);
        check("R2 pulses", {24'h0, q_init, q_flush}, 32'h0);
        check("R2 pending", 32'(q_disable_pending), 32'h0);
        for (int q = 0; q < 4; q++) begin
            do_read(ctl_a(q), rd);
            check("R2 ctl read", rd, (q == 0) ? 32'h1 : 32'h0);
            do_read(wbl_a(q), rd);
            check("R2 wbl read", rd, 32'h0);
        end

        // R3 R6 R7 R10 R1: sweep every control pattern on every queue
        for (int q = 0; q < 4; q++) begin
            for (int p = 0; p < 16; p++) begin
                logic [3:0] pb;
                pb = 4'(p);
                do_write(ctl_a(q), 32'hFFFF_FFF0 | 32'(p));
                check("R3 init pulse", 32'(q_init), pb[0] ? (32'h1 << q) : 32'h0);
                check("R6 flush pulse", 32'(q_flush), pb[1] ? (32'h1 << q) : 32'h0);
                @(negedge clk);
                check("R3 R6 pulse ends", {24'h0, q_init, q_flush}, 32'h0);
                check("R7 priority", 32'(q_prio[q]), 32'(pb[2]));
                check("R4 immediate enable", 32'(q_enable[q]), 32'(pb[0]));
                check("R8 desc wb", 32'(q_desc_wb_en[q]), 32'(pb[3]));
                do_read(ctl_a(q), rd);
                check("R10 R1 ctl read", rd, {28'h0, pb[3], pb[2], 1'b0, pb[0]});
                dwb_m[q] = pb[3];
            end
        end

        // R9 R8: write-back words on every queue
        for (int q = 0; q < 4; q++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] d;
                d = (32'h9E37_79B9 * 32'(q * 4 + k + 1)) ^ 32'(k & 1) ^ 32'h2;
                do_write(wbl_a(q), d);
                check("R9 wb addr out", q_wb_addr[q*32 +: 32], d & 32'hFFFF_FFFC);
                check("R8 head en", 32'(q_head_wb_en[q]), 32'(d[0]));
                check("R8 override", 32'(q_desc_wb_en[q]), 32'(dwb_m[q] & ~d[0]));
                do_read(wbl_a(q), rd);
                check("R9 wb read", rd, d & 32'hFFFF_FFFD);
            end
        end

        // R1: undecoded addresses read 0 and writes there change nothing
        for (int q = 0; q < 5; q++) begin
            do_read(16'(32'h3800 + 32'h100 * q + 32'h2C), rd);
            check("R1 undecoded", rd, 32'h0);
            do_read(16'(32'h3800 + 32'h100 * q), rd);
            check("R1 undecoded", rd, 32'h0);
        end
        do_write(16'h392C, 32'h0);
        do_read(ctl_a(1), rd);
        check("R1 stray write", rd, 32'h0000_000D);
        @(negedge clk);
        check("R1 rdata clears", rdata, 32'h0);

        // R4: disable held until idle
        do_write(ctl_a(2), 32'h1);
        @(negedge clk); q_idle[2] = 1'b0;
        do_write(ctl_a(2), 32'h0);
        check("R4 held enable", 32'(q_enable[2]), 32'h1);
        check("R4 pending", 32'(q_disable_pending[2]), 32'h1);
        repeat (3) @(negedge clk);
        do_read(ctl_a(2), rd);
        check("R4 reads 1 while busy", rd, 32'h1);
        q_idle[2] = 1'b1;
        @(negedge clk);
        check("R4 drops on idle", 32'(q_enable[2]), 32'h0);
        check("R4 pending cleared", 32'(q_disable_pending[2]), 32'h0);

        // R11: re-enable in the same edge idle rises
        @(negedge clk); q_idle[1] = 1'b0;
        do_write(ctl_a(1), 32'h0);
        check("R11 pending set", 32'(q_disable_pending[1]), 32'h1);
        @(negedge clk);
        wr_en = 1'b1; addr = ctl_a(1); wdata = 32'h1; q_idle[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 stays enabled", 32'(q_enable[1]), 32'h1);
        check("R11 pending cancelled", 32'(q_disable_pending[1]), 32'h0);
        check("R11 init", 32'(q_init), 32'h2);

        // R4: disable write in the same edge idle rises drops at once
        @(negedge clk); q_idle[3] = 1'b0;
        do_write(ctl_a(3), 32'h0);
        @(negedge clk);
        wr_en = 1'b1; addr = ctl_a(3); wdata = 32'h0; q_idle[3] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 same-edge drop", {28'h0, q_enable[3], q_disable_pending[3], 2'b0}, 32'h0);

        // R5: global mask
        @(negedge clk); tx_global_en = 1'b0;
        @(negedge clk);
        check("R5 masked outputs", 32'(q_enable), 32'h0);
        do_read(ctl_a(1), rd);
        check("R5 masked read", rd & 32'h1, 32'h0);
        do_write(ctl_a(0), 32'h1);
        check("R5 no init", 32'(q_init), 32'h0);
        @(negedge clk); tx_global_en = 1'b1;
        @(negedge clk);
        check("R5 restored", 32'(q_enable), 32'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule